// File: doc/BRIEF.md
# Delayed Read Target-Side Requester

This block sits on the far side of a bus bridge and carries out a delayed read that an initiator has already asked for. When an entry reaches the head of the delayed-request queue, the block captures it: start address, bus command, active-low byte enables and a prefetchable flag. It then waits until every earlier posted write has drained, and only then does it request the target bus. Each attempt uses the captured address and command exactly as they were received. If the target retries before any data moves, the block tries again. It keeps trying until data flows, the target or the bus reports an abort, or a programmable attempt budget runs out.

Read data is taken one DWORD per clock with no master wait states. Each DWORD goes straight into the write port of the read-data queue that points back toward the initiator. A prefetchable read fetches up to the next aligned prefetch boundary. The boundary is 2^PF_LOG2 DWORDs. A non-prefetchable read fetches a single DWORD. When the request ends, the block reports a completion status and pops the head entry, so the initiator side can finish the delayed transaction. Running out of attempts always raises the internal system-error flag. The SERR output is driven only when its enable bit is set. A retry limit of 0 stands for 2^32 attempts.

Top module: `dly_read_replay`

## Requirements
- R1: `busReq` never rises unless `postedPending` was low in the previous cycle. While `postedPending` stays high after an entry is captured, no attempt starts.
- R2: Every attempt drives `busAddr` and `busCmd` equal to the `headAddr` and `headCmd` captured from the queue head. Both hold steady for as long as `busReq` stays high.
- R3: For a non-prefetchable entry (`headPref`=0), `busBeN` equals the captured `headBeN`. For a prefetchable entry, `busBeN` is 4'b0000, which enables all bytes.
- R4: A response of code 2 (stop without data) that arrives before any data has moved ends the attempt. A new attempt then starts, with `busReq` low for at least one cycle in between. The number of attempts is therefore the number of such stops plus one.
- R5: Once at least one DWORD has moved, the request completes with status 0 (ok) and no further attempt starts. This holds for a stop (code 2), a disconnect with data (code 1), or the final planned data phase.
- R6: When a stop without data arrives and the attempt count has reached `retryLimit`, the request completes with status 3 (exhausted) and `sysErr` pulses. `serrOut` pulses in the same cycle only if `serrEn` is 1. With a limit of L, exactly L attempts are made.
- R7: The attempt count restarts from zero for every new queue-head entry.
- R8: Every response of code 0 or 1 writes `rspData` into the read-data queue in the same cycle through `rdqWrEn`/`rdqWrData`. Consecutive clocks can each carry one DWORD.
- R9: When there is no disconnect, a prefetchable read moves 2^PF_LOG2 − (start DWORD index mod 2^PF_LOG2) DWORDs, and a non-prefetchable read moves 1 DWORD. `busLast` marks the final planned phase.
- R10: A target abort (code 3) completes the request with status 1. A master abort (code 4) completes it with status 2. No further attempt starts after either.
- R11: After reset, `busReq`, `rdqWrEn`, `doneValid` and `headPop` are all low. `doneValid` and `headPop` pulse together for one cycle per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headValid | input | 1 | Queue head holds a delayed read |
| headAddr | input | AW | Captured start byte address (DWORD aligned) |
| headCmd | input | 4 | Captured bus command |
| headBeN | input | 4 | Captured active-low byte enables |
| headPref | input | 1 | Entry is prefetchable |
| headPop | output | 1 | Head entry consumed |
| postedPending | input | 1 | Earlier posted writes not yet delivered |
| retryLimit | input | 32 | Attempt budget (0 means 2^32) |
| serrEn | input | 1 | System error reporting enable |
| busReq | output | 1 | Attempt in progress on the target bus |
| busAddr | output | AW | Address driven for the attempt |
| busCmd | output | 4 | Command driven for the attempt |
| busBeN | output | 4 | Byte enables driven on data phases |
| busLast | output | 1 | Current phase is the final planned one |
| rspValid | input | 1 | Target response present this cycle |
| rspCode | input | 3 | 0 data, 1 data+disconnect, 2 stop without data, 3 target abort, 4 master abort |
| rspData | input | DW | Read DWORD accompanying codes 0 and 1 |
| rdqWrEn | output | 1 | Write strobe into opposite-direction read queue |
| rdqWrData | output | DW | DWORD written into the read queue |
| doneValid | output | 1 | Request finished this cycle |
| doneStatus | output | 2 | 0 ok, 1 target abort, 2 master abort, 3 exhausted |
| sysErr | output | 1 | Attempt budget ran out |
| serrOut | output | 1 | System error output, gated by serrEn |

## Verification
The bench builds the block with PF_LOG2 = 3, so a prefetch window is eight DWORDs. This lets it reach both a full window and the one-DWORD case at the last slot within a short run. It drives `retryLimit` at 3, which makes budget exhaustion and the per-entry restart of the attempt count happen within a handful of cycles. The large default limit and the zero-means-2^32 encoding stay out of reach.

// File: rtl/dly_read_pkg.sv
`timescale 1ns/1ps
package dly_read_pkg;
  typedef enum logic [2:0] {
    RSP_DATA      = 3'd0,
    RSP_DATA_DISC = 3'd1,
    RSP_STOP      = 3'd2,
    RSP_TABORT    = 3'd3,
    RSP_MABORT    = 3'd4
  } rspCode_e;

  typedef enum logic [1:0] {
    STAT_OK      = 2'd0,
    STAT_TABORT  = 2'd1,
    STAT_MABORT  = 2'd2,
    STAT_EXHAUST = 2'd3
  } doneStat_e;

  typedef struct packed {
    logic load;      // capture queue head, clear attempt count
    logic takeWord;  // one DWORD moved
    logic bumpCnt;   // one attempt ended without data
  } dpStrobe_t;
endpackage

// File: rtl/dly_read_dpath.sv
`timescale 1ns/1ps
module dly_read_dpath
  import dly_read_pkg::*;
#(
  parameter int AW      = 32,
  parameter int PF_LOG2 = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic [AW-1:0]   headAddr,
  input  logic [3:0]      headCmd,
  input  logic [3:0]      headBeN,
  input  logic            headPref,
  input  logic [31:0]     retryLimit,
  output logic [AW-1:0]   busAddr,
  output logic [3:0]      busCmd,
  output logic [3:0]      busBeN,
  output logic            lastPhase,
  output logic            limitHit
);
  localparam int REM_W = PF_LOG2 + 1;
  localparam int BURST = 1 << PF_LOG2;

  logic [AW-1:0]  capAddr;
  logic [3:0]     capCmd;
  logic [3:0]     capBeN;
  logic           capPref;
  logic [REM_W-1:0] remaining;
  logic [31:0]    attemptCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr    <= '0;
      capCmd     <= '0;
      capBeN     <= '1;
      capPref    <= 1'b0;
      remaining  <= '0;
      attemptCnt <= '0;
    end else if (strobe.load) begin
      capAddr    <= headAddr;
      capCmd     <= headCmd;
      capBeN     <= headBeN;
      capPref    <= headPref;
      remaining  <= headPref ? (REM_W'(BURST) - REM_W'(headAddr[PF_LOG2+1:2]))
                             : REM_W'(1);
      attemptCnt <= '0;
    end else begin
      if (strobe.takeWord) remaining  <= remaining - 1'b1;
      if (strobe.bumpCnt)  attemptCnt <= attemptCnt + 32'd1;
    end
  end

  assign busAddr   = capAddr;
  assign busCmd    = capCmd;
  assign busBeN    = capPref ? 4'b0000 : capBeN;
  assign lastPhase = (remaining == REM_W'(1));
  // 32-bit wrap makes a limit of 0 mean 2^32 attempts
  assign limitHit  = ((attemptCnt + 32'd1) == retryLimit);

  // R9: no word is taken beyond the planned burst
  a_r9_word_within_burst: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeWord |-> (remaining != '0));
endmodule

// File: rtl/dly_read_ctrl.sv
`timescale 1ns/1ps
module dly_read_ctrl
  import dly_read_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      headValid,
  input  logic      postedPending,
  input  logic      rspValid,
  input  logic [2:0] rspCode,
  input  logic      lastPhase,
  input  logic      limitHit,
  output dpStrobe_t strobe,
  output logic      busReq,
  output logic      rdqWrEn,
  output logic      doneValid,
  output logic [1:0] doneStatus,
  output logic      sysErr
);
  typedef enum logic [1:0] {S_IDLE, S_ARM, S_BUS, S_DONE} state_e;

  state_e    state, nxtState;
  doneStat_e status, nxtStatus;
  logic      dataSeen, nxtSeen;

  always_comb begin
    strobe    = '0;
    rdqWrEn   = 1'b0;
    nxtState  = state;
    nxtStatus = status;
    nxtSeen   = dataSeen;
    unique case (state)
      S_IDLE: if (headValid) begin
        strobe.load = 1'b1;
        nxtSeen     = 1'b0;
        nxtStatus   = STAT_OK;
        nxtState    = S_ARM;
      end
      S_ARM: if (!postedPending) nxtState = S_BUS;
      S_BUS: if (rspValid) begin
        case (rspCode_e'(rspCode))
          RSP_DATA: begin
            rdqWrEn         = 1'b1;
            strobe.takeWord = 1'b1;
            nxtSeen         = 1'b1;
            if (lastPhase) nxtState = S_DONE;
          end
          RSP_DATA_DISC: begin
            rdqWrEn         = 1'b1;
            strobe.takeWord = 1'b1;
            nxtSeen         = 1'b1;
            nxtState        = S_DONE;
          end
          RSP_STOP: begin
            if (dataSeen) nxtState = S_DONE;
            else if (limitHit) begin
              nxtStatus = STAT_EXHAUST;
              nxtState  = S_DONE;
            end else begin
              strobe.bumpCnt = 1'b1;
              nxtState       = S_ARM;
            end
          end
          RSP_TABORT: begin
            nxtStatus = STAT_TABORT;
            nxtState  = S_DONE;
          end
          RSP_MABORT: begin
            nxtStatus = STAT_MABORT;
            nxtState  = S_DONE;
          end
          default: ;
        endcase
      end
      S_DONE: nxtState = S_IDLE;
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      status   <= STAT_OK;
      dataSeen <= 1'b0;
    end else begin
      state    <= nxtState;
      status   <= nxtStatus;
      dataSeen <= nxtSeen;
    end
  end

  assign busReq     = (state == S_BUS);
  assign doneValid  = (state == S_DONE);
  assign doneStatus = status;
  assign sysErr     = (state == S_DONE) && (status == STAT_EXHAUST);

  // R1: an attempt only starts after posted writes have drained
  a_r1_posted_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> !$past(postedPending));
  // R5: once data has moved, no new attempt is armed
  a_r5_no_rearm_after_data: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ARM) |-> !dataSeen);
endmodule

// File: rtl/dly_read_replay.sv
`timescale 1ns/1ps
module dly_read_replay
  import dly_read_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int PF_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          headValid,
  input  logic [AW-1:0] headAddr,
  input  logic [3:0]    headCmd,
  input  logic [3:0]    headBeN,
  input  logic          headPref,
  output logic          headPop,
  input  logic          postedPending,
  input  logic [31:0]   retryLimit,
  input  logic          serrEn,
  output logic          busReq,
  output logic [AW-1:0] busAddr,
  output logic [3:0]    busCmd,
  output logic [3:0]    busBeN,
  output logic          busLast,
  input  logic          rspValid,
  input  logic [2:0]    rspCode,
  input  logic [DW-1:0] rspData,
  output logic          rdqWrEn,
  output logic [DW-1:0] rdqWrData,
  output logic          doneValid,
  output logic [1:0]    doneStatus,
  output logic          sysErr,
  output logic          serrOut
);
  dpStrobe_t strobe;
  logic      lastPhase;
  logic      limitHit;

  dly_read_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .headValid(headValid), .postedPending(postedPending),
    .rspValid(rspValid), .rspCode(rspCode), .lastPhase(lastPhase), .limitHit(limitHit),
    .strobe(strobe), .busReq(busReq), .rdqWrEn(rdqWrEn), .doneValid(doneValid),
    .doneStatus(doneStatus), .sysErr(sysErr)
  );

  dly_read_dpath #(.AW(AW), .PF_LOG2(PF_LOG2)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headAddr(headAddr), .headCmd(headCmd),
    .headBeN(headBeN), .headPref(headPref), .retryLimit(retryLimit),
    .busAddr(busAddr), .busCmd(busCmd), .busBeN(busBeN),
    .lastPhase(lastPhase), .limitHit(limitHit)
  );

  assign headPop   = doneValid;
  assign busLast   = busReq && lastPhase;
  assign rdqWrData = rspData;
  assign serrOut   = sysErr && serrEn;

  // R6: the external error output follows the enable and the exhausted status
  a_r6_serr_gated: assert property (@(posedge clk) disable iff (!rstN)
    serrOut |-> (serrEn && doneValid && (doneStatus == 2'd3)));
  // R2: address and command hold for the whole attempt
  a_r2_attempt_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && $past(busReq)) |-> ($stable(busAddr) && $stable(busCmd)));
endmodule

// File: tb/dly_read_replay_tb.sv
`timescale 1ns/1ps
module dly_read_replay_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int PF_LOG2 = 3;
  localparam int BURST = 1 << PF_LOG2;
  localparam int LIMIT = 3;

  // modes: 0 run to boundary, 1 disconnect with data on word stopAt,
  // 2 stop after stopAt words, 3 target abort, 4 master abort, 5 never any data
  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic [3:0]  beN;
    logic        pref;
    logic [3:0]  nRetry;
    logic [2:0]  mode;
    logic [3:0]  stopAt;
    logic [3:0]  hold;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 4'h6, 4'b1010, 1'b0, 4'd0, 3'd0, 4'd0, 4'd0},
    '{32'h0000_2004, 4'hC, 4'b1111, 1'b1, 4'd2, 3'd0, 4'd0, 4'd0},
    '{32'h0000_201C, 4'hE, 4'b0110, 1'b1, 4'd0, 3'd0, 4'd0, 4'd0},
    '{32'h0000_3000, 4'hC, 4'b0000, 1'b1, 4'd1, 3'd1, 4'd3, 4'd0},
    '{32'h0000_3008, 4'h6, 4'b1100, 1'b1, 4'd0, 3'd2, 4'd2, 4'd0},
    '{32'h0000_4000, 4'h6, 4'b0011, 1'b0, 4'd1, 3'd3, 4'd0, 4'd0},
    '{32'h0000_5010, 4'hE, 4'b1110, 1'b1, 4'd0, 3'd4, 4'd0, 4'd0},
    '{32'h0000_6000, 4'hC, 4'b0101, 1'b1, 4'd2, 3'd0, 4'd0, 4'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic headValid = 1'b0;
  logic [AW-1:0] headAddr = '0;
  logic [3:0] headCmd = '0;
  logic [3:0] headBeN = '1;
  logic headPref = 1'b0;
  logic headPop;
  logic postedPending = 1'b0;
  logic [31:0] retryLimit = LIMIT;
  logic serrEn = 1'b0;
  logic busReq;
  logic [AW-1:0] busAddr;
  logic [3:0] busCmd, busBeN;
  logic busLast;
  logic rspValid = 1'b0;
  logic [2:0] rspCode = '0;
  logic [DW-1:0] rspData = '0;
  logic rdqWrEn;
  logic [DW-1:0] rdqWrData;
  logic doneValid;
  logic [1:0] doneStatus;
  logic sysErr, serrOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dly_read_replay #(.AW(AW), .DW(DW), .PF_LOG2(PF_LOG2)) u_dut (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headAddr(headAddr),
    .headCmd(headCmd), .headBeN(headBeN), .headPref(headPref), .headPop(headPop),
    .postedPending(postedPending), .retryLimit(retryLimit), .serrEn(serrEn),
    .busReq(busReq), .busAddr(busAddr), .busCmd(busCmd), .busBeN(busBeN),
    .busLast(busLast), .rspValid(rspValid), .rspCode(rspCode), .rspData(rspData),
    .rdqWrEn(rdqWrEn), .rdqWrData(rdqWrData), .doneValid(doneValid),
    .doneStatus(doneStatus), .sysErr(sysErr), .serrOut(serrOut)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int burstLen(input vec_t v);
    if (!v.pref) return 1;
    return BURST - int'((v.addr >> 2) % BURST);
  endfunction

  function automatic int expWords(input vec_t v);
    int len = burstLen(v);
    case (v.mode)
      3'd1, 3'd2: return (int'(v.stopAt) < len) ? int'(v.stopAt) : len;
      3'd0:       return len;
      default:    return 0;
    endcase
  endfunction

  function automatic logic [1:0] expStat(input vec_t v);
    case (v.mode)
      3'd3: return 2'd1;
      3'd4: return 2'd2;
      3'd5: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic runEntry(input vec_t v, input string name);
    int retriesLeft = int'(v.nRetry);
    int words = 0;
    int attempts = 0;
    bit prevReq = 0;
    bit addrOk = 1, beOk = 1, dataOk = 1, lastOk = 1, holdOk = 1;
    bit done = 0, popOk = 0;
    logic [1:0] gotStat = '0;
    logic gotSerr = 0, gotSys = 0;
    logic [DW-1:0] expData;
    @(negedge clk);
    headValid = 1'b1;
    headAddr = v.addr; headCmd = v.cmd; headBeN = v.beN; headPref = v.pref;
    postedPending = (v.hold != 0);
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      rspValid = 1'b0;
      if (cyc == int'(v.hold)) postedPending = 1'b0;
      if (cyc < int'(v.hold) && busReq) holdOk = 0;
      if (doneValid) begin
        gotStat = doneStatus; gotSerr = serrOut; gotSys = sysErr; popOk = headPop;
        done = 1;
        headValid = 1'b0;
      end else if (busReq) begin
        if (!prevReq) attempts++;
        if (busAddr != v.addr || busCmd != v.cmd) addrOk = 0;
        if (busBeN != (v.pref ? 4'b0000 : v.beN)) beOk = 0;
        if (busLast != (words == burstLen(v) - 1)) lastOk = 0;
        expData = {v.addr[15:0], 16'(words)};
        rspValid = 1'b1;
        rspData = expData;
        if (v.mode == 3'd5) rspCode = 3'd2;
        else if (retriesLeft > 0) begin rspCode = 3'd2; retriesLeft--; end
        else if (v.mode == 3'd3) rspCode = 3'd3;
        else if (v.mode == 3'd4) rspCode = 3'd4;
        else if (v.mode == 3'd2 && words == int'(v.stopAt)) rspCode = 3'd2;
        else if (v.mode == 3'd1 && words + 1 == int'(v.stopAt)) rspCode = 3'd1;
        else rspCode = 3'd0;
        #1;
        if (rdqWrEn) begin
          if (rdqWrData != expData) dataOk = 0;
          words++;
        end
      end
      prevReq = busReq;
      if (!done) @(negedge clk);
    end
    rspValid = 1'b0;
    chk(done, {name, " R11 completion seen"}, done, 1);
    chk(popOk, {name, " R11 head popped with done"}, popOk, 1);
    chk(holdOk, {name, " R1 no request while posted writes pending"}, holdOk, 1);
    chk(addrOk, {name, " R2 address/command replayed"}, addrOk, 1);
    chk(beOk, {name, " R3 byte enables"}, beOk, 1);
    chk(words == expWords(v), {name, " R9/R5 DWORD count"}, words, expWords(v));
    chk(dataOk, {name, " R8 read data into queue"}, dataOk, 1);
    chk(lastOk, {name, " R9 last phase marker"}, lastOk, 1);
    chk(gotStat == expStat(v), {name, " R10/R5 status"}, gotStat, expStat(v));
    chk(attempts == ((v.mode == 3'd5) ? LIMIT : int'(v.nRetry) + 1),
        {name, " R4/R7 attempt count"}, attempts,
        (v.mode == 3'd5) ? LIMIT : int'(v.nRetry) + 1);
    chk(gotSys == (v.mode == 3'd5), {name, " R6 system error flag"}, gotSys, v.mode == 3'd5);
    chk(gotSerr == ((v.mode == 3'd5) && serrEn), {name, " R6 SERR gating"},
        gotSerr, (v.mode == 3'd5) && serrEn);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busReq && !rdqWrEn && !doneValid && !headPop, "R11 reset outputs idle",
        {busReq, rdqWrEn, doneValid, headPop}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busReq, "R11 idle without head entry", busReq, 0);

    foreach (VECS[i]) runEntry(VECS[i], $sformatf("vec%0d", i));

    // R1: posted writes still pending for several cycles
    runEntry('{32'h0000_7000, 4'h6, 4'b1001, 1'b0, 4'd0, 3'd0, 4'd0, 4'd9}, "posted_hold");
    // R6/R7: budget exhausted with reporting enabled, then disabled
    serrEn = 1'b1;
    runEntry('{32'h0000_8000, 4'hC, 4'b0000, 1'b1, 4'd0, 3'd5, 4'd0, 4'd0}, "exhaust_en");
    serrEn = 1'b0;
    runEntry('{32'h0000_8040, 4'h6, 4'b0111, 1'b0, 4'd0, 3'd5, 4'd0, 4'd0}, "exhaust_dis");
    // R5: stop right after the first word of a prefetchable read
    runEntry('{32'h0000_9000, 4'hE, 4'b1111, 1'b1, 4'd1, 3'd2, 4'd1, 4'd2}, "stop_after_one");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule